// File: doc/BRIEF.md
# NaN Precision Translator

This combinational unit moves a NaN operand between the single (32-bit) and double (64-bit) IEEE binary formats. It also passes a NaN through unchanged within one format. The source NaN is first decoded into a neutral middle form: a sign bit and a 64-bit payload field, with the fraction packed against the top of that field. The destination is then built from that form. Because every conversion goes through the same middle form, narrowing a double keeps only the upper fraction bits. Widening a single fills the new low fraction bits with zeros.

The unit decides whether the source is a quiet or a signaling NaN, and it flags an invalid operation for a signaling source. Which value of the top fraction bit means "quiet" is chosen at run time. That choice also changes the canonical default NaN. The default NaN replaces the result in two cases: when default-NaN mode is on, and when the payload left after narrowing is zero. The result is not silenced. The payload is carried as it is, and the invalid flag tells the caller what happened.

Top module: `nan_fmt_xlate`

## Requirements
- R1: With `snan_msb_one`=0, a single source (exponent bits 30:23 all ones, fraction 22:0 nonzero) is quiet when fraction bit 22 is 1 and signaling when it is 0.
- R2: With `snan_msb_one`=0, a double source (exponent 62:52 all ones, fraction 51:0 nonzero) is quiet when bit 51 is 1 and signaling when it is 0.
- R3: With `snan_msb_one`=1, the quiet and signaling meanings of the top fraction bit are swapped, for both formats.
- R4: `invalid` is 1 exactly when the source is a signaling NaN. A non-NaN source never raises it.
- R5: Single to double (`fmt_sel`=2'b00) gives {sign, 11'h7FF, frac[22:0], 29'b0}.
- R6: Double to single (`fmt_sel`=2'b01) gives {32'b0, sign, 8'hFF, frac[51:29]} when frac[51:29] is nonzero.
- R7: When the payload kept for the destination is zero, the output is the default NaN for the destination format.
- R8: The default NaN has sign 0 and an all-ones exponent. With `snan_msb_one`=0 only the top fraction bit is set (single 32'h7FC00000, double 64'h7FF8000000000000). With `snan_msb_one`=1 every fraction bit except the top one is set (32'h7FBFFFFF, 64'h7FF7FFFFFFFFFFFF).
- R9: With `dflt_nan_en`=1 the output is always the destination default NaN. `invalid` still follows R4.
- R10: Single to single (2'b10) and double to double (2'b11) return a NaN source bit for bit, with the upper 32 bits zero for single.
- R11: `fmt_sel` bit 0 selects a double source. The destination is double for 2'b00 and 2'b11.
- R12: A single source ignores `src_val[63:32]`. A single result drives `dst_val[63:32]` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Source NaN; a single occupies bits 31:0 |
| fmt_sel | input | 2 | Translation code: 00 S→D, 01 D→S, 10 S→S, 11 D→D |
| snan_msb_one | input | 1 | 1: a set top fraction bit marks a signaling NaN |
| dflt_nan_en | input | 1 | Force the default NaN as the result |
| dst_val | output | 64 | Destination NaN; a single occupies bits 31:0 |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The unit holds no state, so a fault shows at the ports in the same evaluation as the stimulus. A misplaced payload shows up as wrong fraction bits or as an unexpected fallback to the default NaN. A wrong polarity decode shows up as the `invalid` flag inverted against the top fraction bit. Walking-one payloads in every fraction position, for both polarities and all four codes, expose any single shifted or dropped bit. Single→double→single round trips confirm that the two directions agree.

// File: rtl/nanfx_pkg.sv
package nanfx_pkg;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int CAN_W      = 64;

  typedef enum logic [1:0] {
    XL_S2D = 2'b00,
    XL_D2S = 2'b01,
    XL_S2S = 2'b10,
    XL_D2D = 2'b11
  } xlate_e;

  function automatic logic src_is_dbl(input logic [1:0] code);
    return code[0];
  endfunction

  function automatic logic dst_is_dbl(input logic [1:0] code);
    return ~(code[1] ^ code[0]);
  endfunction
endpackage

// File: rtl/nanfx_decode.sv
module nanfx_decode #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CAN_W  = 64,
  localparam int VAL_W = 1 + EXP_W + FRAC_W,
  localparam int PAD_W = CAN_W - FRAC_W
) (
  input  logic [VAL_W-1:0] val,
  input  logic             inv_pol,
  output logic             is_quiet,
  output logic             is_sig,
  output logic             can_sign,
  output logic [CAN_W-1:0] can_hi
);
  logic             exp_ones;
  logic             frac_nz;
  logic             top_bit;
  logic             is_nan;

  always_comb begin
    exp_ones = &val[VAL_W-2 -: EXP_W];
    frac_nz  = |val[FRAC_W-1:0];
    top_bit  = val[FRAC_W-1];
    is_nan   = exp_ones & frac_nz;
    is_quiet = is_nan & (top_bit ^ inv_pol);
    is_sig   = is_nan & ~(top_bit ^ inv_pol);
    can_sign = val[VAL_W-1];
    can_hi   = {val[FRAC_W-1:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/nanfx_encode.sv
module nanfx_encode #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CAN_W  = 64,
  localparam int VAL_W = 1 + EXP_W + FRAC_W,
  localparam int PAD_W = CAN_W - FRAC_W
) (
  input  logic             can_sign,
  input  logic [CAN_W-1:0] can_hi,
  input  logic             inv_pol,
  input  logic             force_dflt,
  output logic [VAL_W-1:0] val,
  output logic             used_dflt,
  output logic             dropped_nz
);
  logic [FRAC_W-1:0] payload;
  logic [FRAC_W-1:0] dflt_frac;

  always_comb begin
    payload    = can_hi[CAN_W-1 -: FRAC_W];
    dropped_nz = |can_hi[PAD_W-1:0];
    dflt_frac  = inv_pol ? {1'b0, {(FRAC_W-1){1'b1}}}
                         : {1'b1, {(FRAC_W-1){1'b0}}};
    used_dflt  = force_dflt | ~(|payload);
    if (used_dflt) val = {1'b0, {EXP_W{1'b1}}, dflt_frac};
    else           val = {can_sign, {EXP_W{1'b1}}, payload};
  end
endmodule

// File: rtl/nan_fmt_xlate.sv
module nan_fmt_xlate
  import nanfx_pkg::*;
(
  input  logic [DBL_W-1:0] src_val,
  input  logic [1:0]       fmt_sel,
  input  logic             snan_msb_one,
  input  logic             dflt_nan_en,
  output logic [DBL_W-1:0] dst_val,
  output logic             invalid
);
  logic             src_dbl, dst_dbl;
  logic             s_quiet, s_sig, s_sign;
  logic             d_quiet, d_sig, d_sign;
  logic [CAN_W-1:0] s_hi, d_hi;
  logic             src_quiet, src_sig, mid_sign;
  logic [CAN_W-1:0] mid_hi;
  logic [SGL_W-1:0] s_out;
  logic [DBL_W-1:0] d_out;
  logic             s_used_dflt, d_used_dflt;
  logic             s_dropped_nz, d_dropped_nz;

  assign src_dbl = src_is_dbl(fmt_sel);
  assign dst_dbl = dst_is_dbl(fmt_sel);

  nanfx_decode #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .CAN_W(CAN_W)) u_dec_s (
    .val(src_val[SGL_W-1:0]), .inv_pol(snan_msb_one),
    .is_quiet(s_quiet), .is_sig(s_sig), .can_sign(s_sign), .can_hi(s_hi));

  nanfx_decode #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .CAN_W(CAN_W)) u_dec_d (
    .val(src_val), .inv_pol(snan_msb_one),
    .is_quiet(d_quiet), .is_sig(d_sig), .can_sign(d_sign), .can_hi(d_hi));

  always_comb begin
    src_quiet = src_dbl ? d_quiet : s_quiet;
    src_sig   = src_dbl ? d_sig   : s_sig;
    mid_sign  = src_dbl ? d_sign  : s_sign;
    mid_hi    = src_dbl ? d_hi    : s_hi;
  end

  nanfx_encode #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .CAN_W(CAN_W)) u_enc_s (
    .can_sign(mid_sign), .can_hi(mid_hi), .inv_pol(snan_msb_one),
    .force_dflt(dflt_nan_en), .val(s_out), .used_dflt(s_used_dflt),
    .dropped_nz(s_dropped_nz));

  nanfx_encode #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .CAN_W(CAN_W)) u_enc_d (
    .can_sign(mid_sign), .can_hi(mid_hi), .inv_pol(snan_msb_one),
    .force_dflt(dflt_nan_en), .val(d_out), .used_dflt(d_used_dflt),
    .dropped_nz(d_dropped_nz));

  assign dst_val = dst_dbl ? d_out : {{(DBL_W-SGL_W){1'b0}}, s_out};
  assign invalid = src_sig;
endmodule

// File: rtl/nan_fmt_xlate_chk.sv
module nan_fmt_xlate_chk (
  input logic [63:0] src_val,
  input logic [1:0]  fmt_sel,
  input logic        dflt_nan_en,
  input logic [63:0] dst_val,
  input logic        invalid,
  input logic        dst_dbl,
  input logic        src_quiet,
  input logic        src_sig,
  input logic        s_used_dflt,
  input logic        d_used_dflt,
  input logic        s_dropped_nz,
  input logic        d_dropped_nz
);
  always_comb begin
    if (!$isunknown({src_val, fmt_sel, dflt_nan_en})) begin
      AST_CLASS_DISJOINT: assert (!(src_quiet && src_sig)); // R1
      AST_INVALID_NEEDS_NAN_EXP: assert (!invalid || (fmt_sel[0] ? (&src_val[62:52]) : (&src_val[30:23]))); // R4
      AST_SINGLE_UPPER_ZERO: assert (dst_dbl || dst_val[63:32] == 32'h0); // R12
      AST_DFLT_FORCED: assert (!dflt_nan_en || (dst_dbl ? d_used_dflt : s_used_dflt)); // R9
      AST_WIDEN_KEEPS_ALL: assert (fmt_sel != 2'b00 || !d_dropped_nz); // R5
      AST_SAME_SGL_KEEPS_ALL: assert (fmt_sel != 2'b10 || !s_dropped_nz); // R10
      AST_RESULT_IS_NAN: assert (dst_dbl ? ((&dst_val[62:52]) && (|dst_val[51:0]))
                                         : ((&dst_val[30:23]) && (|dst_val[22:0]))); // R7
    end
  end
endmodule

bind nan_fmt_xlate nan_fmt_xlate_chk u_chk (
  .src_val(src_val), .fmt_sel(fmt_sel), .dflt_nan_en(dflt_nan_en),
  .dst_val(dst_val), .invalid(invalid), .dst_dbl(dst_dbl),
  .src_quiet(src_quiet), .src_sig(src_sig),
  .s_used_dflt(s_used_dflt), .d_used_dflt(d_used_dflt),
  .s_dropped_nz(s_dropped_nz), .d_dropped_nz(d_dropped_nz));

// File: tb/nan_fmt_xlate_bench.sv
module nan_fmt_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_val = 64'h0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        snan_msb_one = 1'b0;
  logic        dflt_nan_en = 1'b0;
  logic [63:0] dst_val;
  logic        invalid;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nan_fmt_xlate u_nan_fmt_xlate (
    .src_val(src_val), .fmt_sel(fmt_sel), .snan_msb_one(snan_msb_one),
    .dflt_nan_en(dflt_nan_en), .dst_val(dst_val), .invalid(invalid));

  function automatic logic [63:0] dflt_of(input bit dbl, input bit pol);
    if (dbl) return pol ? 64'h7FF7FFFFFFFFFFFF : 64'h7FF8000000000000;
    return pol ? 64'h000000007FBFFFFF : 64'h000000007FC00000;
  endfunction

  task automatic model(input logic [63:0] s, input logic [1:0] f, input bit pol,
                       input bit dm, output logic [63:0] d, output bit inv);
    bit sd, dd, sg, ones, nz, top;
    logic [51:0] fr;
    sd = f[0];
    dd = (f == 2'b00) || (f == 2'b11);
    if (sd) begin
      sg = s[63]; ones = (s[62:52] == 11'h7FF); fr = s[51:0];
    end else begin
      sg = s[31]; ones = (s[30:23] == 8'hFF); fr = {s[22:0], 29'h0};
    end
    nz  = (fr != 52'h0);
    top = fr[51];
    inv = ones && nz && (top == pol);
    if (dm) d = dflt_of(dd, pol);
    else if (dd) d = nz ? {sg, 11'h7FF, fr} : dflt_of(1'b1, pol);
    else d = (fr[51:29] != 23'h0) ? {32'h0, sg, 8'hFF, fr[51:29]} : dflt_of(1'b0, pol);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, input logic [1:0] f, input bit pol, input bit dm);
    @(posedge clk);
    src_val = s; fmt_sel = f; snan_msb_one = pol; dflt_nan_en = dm;
    @(negedge clk);
  endtask

  task automatic run_one(input logic [63:0] s, input logic [1:0] f, input bit pol, input bit dm);
    logic [63:0] ed;
    bit ei;
    string tg;
    apply(s, f, pol, dm);
    model(s, f, pol, dm, ed, ei);
    if (dm) tg = "R9";
    else if (f == 2'b00) tg = "R5";
    else if (f == 2'b01) tg = (s[51:29] == 23'h0) ? "R7" : "R6";
    else tg = "R10";
    check(tg, dst_val, ed);
    check(pol ? "R3" : (f[0] ? "R2" : "R1"), {63'h0, invalid}, {63'h0, ei});
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] s, mid;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R4: non-NaN zero input raises nothing; R7/R8 result falls back to default
    apply(64'h0, 2'b00, 1'b0, 1'b0);
    check("R4", {63'h0, invalid}, 64'h0);
    check("R8", dst_val, 64'h7FF8000000000000);
    // R8 explicit default patterns, R11 code mapping
    apply(64'h0, 2'b01, 1'b0, 1'b1);
    check("R8", dst_val, 64'h000000007FC00000);
    apply(64'h0, 2'b01, 1'b1, 1'b1);
    check("R8", dst_val, 64'h000000007FBFFFFF);
    apply(64'h0, 2'b11, 1'b1, 1'b1);
    check("R8", dst_val, 64'h7FF7FFFFFFFFFFFF);
    apply(64'h00000000FFC00001, 2'b00, 1'b0, 1'b0);
    check("R11", dst_val, 64'hFFF8000020000000);
    // sweeps over polarity, code, mode, sign, walking-one payloads
    for (int pol = 0; pol < 2; pol++)
      for (int f = 0; f < 4; f++)
        for (int dm = 0; dm < 2; dm++)
          for (int sg = 0; sg < 2; sg++)
            for (int top = 0; top < 2; top++) begin
              if (f[0]) begin
                for (int k = 0; k < 52; k++) begin
                  s = {sg[0], 11'h7FF, 52'h0};
                  s[k] = 1'b1;
                  if (top != 0) s[51] = 1'b1;
                  run_one(s, f[1:0], pol[0], dm[0]);
                end
              end else begin
                for (int k = 0; k < 23; k++) begin
                  // R12: junk in the upper half of a single source
                  s = {32'hA5A50F0F, sg[0], 8'hFF, 23'h0};
                  s[k] = 1'b1;
                  if (top != 0) s[22] = 1'b1;
                  run_one(s, f[1:0], pol[0], dm[0]);
                end
              end
            end
    // round trip single -> double -> single (R5 then R6)
    for (int pol = 0; pol < 2; pol++)
      for (int k = 0; k < 23; k++) begin
        s = {32'h0, k[0], 8'hFF, 23'h0};
        s[k] = 1'b1;
        apply(s, 2'b00, pol[0], 1'b0);
        mid = dst_val;
        apply(mid, 2'b01, pol[0], 1'b0);
        check("R6", dst_val, s);
      end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule